// File: doc/BRIEF.md
# SPI Register and Interrupt Controller

This block is the register front end of a serial peripheral interface master. It sits on an 8-bit, single-cycle bus with a 2-bit address. It holds the control, status, data and extension registers, and it turns data-register accesses into push and pop strobes for a transmit FIFO and a receive FIFO, which live outside the block. A shift engine, also outside, reports each completed byte transfer with a one-cycle pulse. The block counts these pulses and sets its interrupt flag only when a programmable block of one to four transfers has finished.

Software programs the enable, clock mode and rate through the control and extension registers. It loads bytes by writing the data address and fetches received bytes by reading the data address. It services the interrupt and clears it by writing a one to the flag. A write collision flag records any data write made while the transmit FIFO is full. The interrupt line is the flag gated by the interrupt enable.

Top module: `spi_regctl`

## Requirements
- R1: An access is valid while `bus_cyc` and `bus_stb` are both high. Each valid access gets exactly one `bus_ack` pulse, one clock long, in the cycle after the access is first seen. `bus_ack` is not asserted again until the valid condition has dropped for at least one cycle. `bus_stb` without `bus_cyc` is never acknowledged.
- R2: Address 0 is the control register, reset value 0x10. Bit 7 is interrupt enable, bit 6 is core enable, bit 3 is clock polarity, bit 2 is clock phase and bits 1:0 are the base rate; these bits read back as written. Bit 5 always reads 0. Bit 4, the master bit, always reads 1.
- R3: Address 3 is the extension register, reset value 0x00. Bits 7:6 hold the block count and bits 1:0 hold the extended rate; these bits read back as written. Bits 5:2 always read 0.
- R4: Address 1 is the status register. Its bits are {flag, collision, 0, 0, `tx_full`, `tx_empty`, `rx_full`, `rx_empty`} from bit 7 down to bit 0. The FIFO bits follow the FIFO inputs, so the register reads 0x05 after reset when both FIFOs are empty.
- R5: A write to address 2 pulses `tx_push` for one cycle, with `tx_data` equal to the written byte.
- R6: A read of address 2 pulses `rx_pop` for one cycle and returns `rx_data` as it stood when the access was taken.
- R7: A write to address 2 while `tx_full` is high sets the collision flag, status bit 6.
- R8: Writing 1 to status bit 7 clears the flag, and writing 1 to status bit 6 clears the collision flag. Writing 0 to either bit leaves it unchanged. The FIFO bits ignore writes.
- R9: With block count c in extension bits 7:6, the flag is set on the (c+1)-th `xfer_done` pulse counted while the core is enabled, and counting then restarts.
- R10: While the core enable is 0, the transfer count is held at zero and `xfer_done` pulses are ignored.
- R11: `irq` is high exactly when the flag and the interrupt enable are both 1. Setting the enable while the flag is already set raises `irq` in the cycle after the write.
- R12: `spi_en` is control bit 6, `cpol` is control bit 3 and `cpha` is control bit 2. `rate_sel` is {extension bits 1:0, control bits 1:0}. `fifo_clr` is the inverse of the core enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Block select strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with ack |
| bus_ack | output | 1 | Access acknowledge |
| irq | output | 1 | Interrupt request |
| tx_push | output | 1 | Push strobe to transmit FIFO |
| tx_data | output | 8 | Byte to push |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| xfer_done | input | 1 | One-cycle pulse per completed transfer |
| spi_en | output | 1 | Core enable |
| cpol | output | 1 | Clock polarity |
| cpha | output | 1 | Clock phase |
| rate_sel | output | 4 | Combined clock rate select |
| fifo_clr | output | 1 | FIFO clear, high while disabled |

## Verification
Several rules are checked on every cycle. The acknowledge is a single pulse and only follows a valid access. Each strobe to the FIFOs lasts one cycle. A data write into a full transmit FIFO always leaves the collision flag set. The count end always sets the flag. A disabled core always holds its count at zero. Whenever the flag and the enable are both set, the interrupt is up.

Other behaviour can only be shown by the bench's scenarios. These are the readback masks of each register and the exact transfer on which a block of one or of three transfers completes. They also include the restart of the count after the core is turned off and on, the write-one-to-clear behaviour together with writes of zero that change nothing, and an acknowledge withheld while the strobe is held high.

// File: rtl/spi_regctl_pkg.sv
package spi_regctl_pkg;
  localparam int DW    = 8;
  localparam int AW    = 2;
  localparam int CNT_W = 2;
  localparam int RATE_W = 4;

  typedef enum logic [AW-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_EXT  = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int C_IE   = 7;
  localparam int C_EN   = 6;
  localparam int C_RSV  = 5;
  localparam int C_MST  = 4;
  localparam int C_POL  = 3;
  localparam int C_PHA  = 2;

  // status bit positions
  localparam int S_FLAG = 7;
  localparam int S_WCOL = 6;

  localparam logic [DW-1:0] CTRL_RST = 8'h10;
  localparam logic [DW-1:0] EXT_RST  = 8'h00;
  localparam logic [DW-1:0] EXT_KEEP = 8'hC3;

  // stored control value from a written byte: reserved bit low, master bit high
  function automatic logic [DW-1:0] ctrl_fix(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    r = w;
    r[C_RSV] = 1'b0;
    r[C_MST] = 1'b1;
    return r;
  endfunction

  function automatic logic [DW-1:0] ext_fix(input logic [DW-1:0] w);
    return w & EXT_KEEP;
  endfunction

  function automatic logic [DW-1:0] stat_pack(input logic flag, input logic wcol,
                                              input logic tf, input logic te,
                                              input logic rf, input logic re);
    return {flag, wcol, 2'b00, tf, te, rf, re};
  endfunction

  // transfers per interrupt block minus one is the stored count itself
  function automatic logic cnt_at_end(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] blk);
    return cnt == blk;
  endfunction
endpackage

// File: rtl/spi_bus_port.sv
module spi_bus_port
  import spi_regctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic          fire,
  output logic          wr_ctrl,
  output logic          wr_stat,
  output logic          wr_data,
  output logic          wr_ext,
  output logic          rd_data,
  output logic          ack
);
  logic valid;
  logic seen_q;

  assign valid = cyc & stb;
  assign fire  = valid & ~seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      ack    <= 1'b0;
    end else begin
      seen_q <= valid;
      ack    <= fire;
    end
  end

  assign wr_ctrl = fire & we & (addr == REG_CTRL);
  assign wr_stat = fire & we & (addr == REG_STAT);
  assign wr_data = fire & we & (addr == REG_DATA);
  assign wr_ext  = fire & we & (addr == REG_EXT);
  assign rd_data = fire & ~we & (addr == REG_DATA);

  // R1
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R1
  ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(valid));
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_regctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_ext,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] ext_q,
  output logic          ie,
  output logic          en,
  output logic [CNT_W-1:0] blk_cnt,
  output logic [RATE_W-1:0] rate
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ext_q  <= EXT_RST;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_fix(wdata);
      if (wr_ext)  ext_q  <= ext_fix(wdata);
    end
  end

  assign ie      = ctrl_q[C_IE];
  assign en      = ctrl_q[C_EN];
  assign blk_cnt = ext_q[DW-1 -: CNT_W];
  assign rate    = {ext_q[1:0], ctrl_q[1:0]};

  // R2
  ctrl_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_MST] && !ctrl_q[C_RSV]);
  // R3
  ext_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q[5:2] == 4'b0000);
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
  import spi_regctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             xfer_done,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             wr_stat,
  input  logic             wr_data,
  input  logic             tx_full,
  input  logic [DW-1:0]    wdata,
  output logic             flag_q,
  output logic             wcol_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             xfer_evt;
  logic             blk_end;
  logic             collide;
  logic             clr_flag;
  logic             clr_wcol;

  assign xfer_evt = en & xfer_done;
  assign blk_end  = xfer_evt & cnt_at_end(cnt_q, blk_cnt);
  assign collide  = wr_data & tx_full;
  assign clr_flag = wr_stat & wdata[S_FLAG];
  assign clr_wcol = wr_stat & wdata[S_WCOL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (xfer_evt) begin
      cnt_q <= blk_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (blk_end)       flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      if (collide)       wcol_q <= 1'b1;
      else if (clr_wcol) wcol_q <= 1'b0;
    end
  end

  // R9
  blk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && en && cnt_q == blk_cnt) |=> flag_q);
  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);
  // R7
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full) |=> wcol_q);
endmodule

// File: rtl/spi_regctl.sv
module spi_regctl
  import spi_regctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ack,
  output logic              irq,
  output logic              tx_push,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_full,
  input  logic              tx_empty,
  output logic              rx_pop,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic              xfer_done,
  output logic              spi_en,
  output logic              cpol,
  output logic              cpha,
  output logic [RATE_W-1:0] rate_sel,
  output logic              fifo_clr
);
  logic fire, wr_ctrl, wr_stat, wr_data, wr_ext, rd_data;
  logic [DW-1:0] ctrl_q, ext_q, rd_mux;
  logic ie, en, flag_q, wcol_q;
  logic [CNT_W-1:0] blk_cnt;

  spi_bus_port u_port (
    .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
    .addr(bus_addr), .fire(fire), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wr_data(wr_data), .wr_ext(wr_ext), .rd_data(rd_data), .ack(bus_ack)
  );

  spi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_ext(wr_ext),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .ext_q(ext_q), .ie(ie), .en(en),
    .blk_cnt(blk_cnt), .rate(rate_sel)
  );

  spi_evt_flags u_evt (
    .clk(clk), .rst_n(rst_n), .en(en), .xfer_done(xfer_done),
    .blk_cnt(blk_cnt), .wr_stat(wr_stat), .wr_data(wr_data),
    .tx_full(tx_full), .wdata(bus_wdata), .flag_q(flag_q), .wcol_q(wcol_q)
  );

  always_comb begin
    unique case (bus_addr)
      REG_CTRL: rd_mux = ctrl_q;
      REG_STAT: rd_mux = stat_pack(flag_q, wcol_q, tx_full, tx_empty,
                                   rx_full, rx_empty);
      REG_DATA: rd_mux = rx_data;
      default:  rd_mux = ext_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bus_rdata <= '0;
    else if (fire) bus_rdata <= rd_mux;
  end

  assign tx_push  = wr_data;
  assign tx_data  = bus_wdata;
  assign rx_pop   = rd_data;
  assign irq      = flag_q & ie;
  assign spi_en   = en;
  assign cpol     = ctrl_q[C_POL];
  assign cpha     = ctrl_q[C_PHA];
  assign fifo_clr = ~en;

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ctrl_q[C_IE]) |-> irq);
  // R5
  push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);
  // R6
  pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop);
endmodule

// File: tb/spi_regctl_tb_top.sv
module spi_regctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 0, stb = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ack, irq, tx_push, rx_pop, spi_en, cpol, cpha, fifo_clr;
  logic [7:0] tx_data;
  logic [3:0] rate_sel;
  logic tx_full = 0, tx_empty = 1, rx_full = 0, rx_empty = 1, xfer = 0;
  logic [7:0] rx_data = 8'hA5;
  int total = 0, bad = 0, push_cnt = 0, pop_cnt = 0;
  logic [7:0] last_push = 0;
  logic [7:0] q;

  always #10 clk = ~clk;

  spi_regctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack),
    .irq(irq), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .xfer_done(xfer),
    .spi_en(spi_en), .cpol(cpol), .cpha(cpha), .rate_sel(rate_sel),
    .fifo_clr(fifo_clr)
  );

  always @(posedge clk) begin
    if (tx_push) begin push_cnt <= push_cnt + 1; last_push <= tx_data; end
    if (rx_pop)  pop_cnt <= pop_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] r);
    @(negedge clk); cyc = 1; stb = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    chk(ack === 1'b1, "R1 ack", ack, 1);
    r = rdata;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    chk(ack === 1'b0, "R1 ack drop", ack, 0);
  endtask

  task automatic pulse;
    @(negedge clk); xfer = 1;
    @(negedge clk); xfer = 0;
  endtask

  // {addr, write data, expected readback}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'h00, 8'h10}, {2'd0, 8'hEF, 8'hDF}, {2'd0, 8'h20, 8'h10},
    {2'd0, 8'hC4, 8'hD4}, {2'd3, 8'hFF, 8'hC3}, {2'd3, 8'h3C, 8'h00},
    {2'd3, 8'h81, 8'h81}, {2'd3, 8'h00, 8'h00}
  };

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int acks;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset values: R2 R3 R4 R11
    acc(0, 2'd0, 0, q); chk(q === 8'h10, "R2 ctrl reset", q, 8'h10);
    acc(0, 2'd1, 0, q); chk(q === 8'h05, "R4 stat reset", q, 8'h05);
    acc(0, 2'd3, 0, q); chk(q === 8'h00, "R3 ext reset", q, 8'h00);
    chk(irq === 1'b0, "R11 irq reset", irq, 0);
    chk(fifo_clr === 1'b1, "R12 fifo_clr reset", fifo_clr, 1);

    // table of register masks: R2 (addr 0) and R3 (addr 3)
    for (int i = 0; i < 8; i++) begin
      acc(1, VEC[i][17:16], VEC[i][15:8], q);
      acc(0, VEC[i][17:16], 0, q);
      chk(q === VEC[i][7:0], VEC[i][17:16] == 0 ? "R2 ctrl mask" : "R3 ext mask",
          q, VEC[i][7:0]);
    end

    // R1: strobe without cycle, and held access
    @(negedge clk); stb = 1; acks = 0;
    repeat (3) begin @(negedge clk); acks += int'(ack); end
    chk(acks == 0, "R1 stb only", acks, 0);
    cyc = 1; acks = 0;
    repeat (4) begin @(negedge clk); acks += int'(ack); end
    cyc = 0; stb = 0;
    @(negedge clk);
    chk(acks == 1, "R1 held access", acks, 1);

    // R12 configuration outputs
    acc(1, 2'd0, 8'h4D, q);
    acc(1, 2'd3, 8'h02, q);
    chk({spi_en, cpol, cpha} === 3'b111, "R12 mode", {spi_en, cpol, cpha}, 7);
    chk(rate_sel === 4'h9, "R12 rate", rate_sel, 9);
    chk(fifo_clr === 1'b0, "R12 fifo_clr", fifo_clr, 0);

    // R5 push
    acc(1, 2'd2, 8'h3C, q);
    chk(push_cnt == 1 && last_push === 8'h3C, "R5 push", last_push, 8'h3C);

    // R4 live FIFO bits and R7 collision
    tx_full = 1; tx_empty = 0; rx_full = 1; rx_empty = 0;
    acc(0, 2'd1, 0, q); chk(q === 8'h0A, "R4 fifo bits", q, 8'h0A);
    rx_full = 0; rx_empty = 1;
    acc(1, 2'd2, 8'h11, q);
    acc(0, 2'd1, 0, q); chk(q === 8'h49, "R7 collision", q, 8'h49);
    // R8 write zero then write one
    acc(1, 2'd1, 8'h00, q);
    acc(0, 2'd1, 0, q); chk(q === 8'h49, "R8 write zero", q, 8'h49);
    acc(1, 2'd1, 8'h40, q);
    acc(0, 2'd1, 0, q); chk(q === 8'h09, "R8 clear wcol", q, 8'h09);
    tx_full = 0; tx_empty = 1;

    // R6 pop
    acc(0, 2'd2, 0, q);
    chk(q === 8'hA5 && pop_cnt == 1, "R6 pop", q, 8'hA5);

    // R9 block of three (count 2)
    acc(1, 2'd3, 8'h80, q);
    pulse; pulse;
    acc(0, 2'd1, 0, q); chk(q[7] === 1'b0, "R9 before block end", q[7], 0);
    pulse;
    acc(0, 2'd1, 0, q); chk(q[7] === 1'b1, "R9 third transfer", q[7], 1);
    // R11: enable set while flag set
    chk(irq === 1'b0, "R11 irq masked", irq, 0);
    acc(1, 2'd0, 8'hC0, q);
    chk(irq === 1'b1, "R11 irq raised", irq, 1);
    // R8 clear flag
    acc(1, 2'd1, 8'h80, q);
    chk(irq === 1'b0, "R8 flag clear irq", irq, 0);
    // R9 block of one
    acc(1, 2'd3, 8'h00, q);
    pulse;
    chk(irq === 1'b1, "R9 single transfer", irq, 1);
    acc(1, 2'd1, 8'h80, q);

    // R10 count reset while disabled
    acc(1, 2'd3, 8'hC0, q);
    pulse; pulse;
    acc(1, 2'd0, 8'h80, q);
    pulse; pulse; pulse; pulse;
    chk(irq === 1'b0, "R10 ignored while off", irq, 0);
    acc(1, 2'd0, 8'hC0, q);
    pulse; pulse; pulse;
    chk(irq === 1'b0, "R10 count restarted", irq, 0);
    pulse;
    chk(irq === 1'b1, "R10 fourth after enable", irq, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule